// File: doc/BRIEF.md
# Programmable Raster Sync Timing Generator

This block produces the horizontal and vertical timing of a video raster. A pixel counter steps once per enabled clock across a line. A line counter steps once per line down a frame. Each pulse edge is a 12-bit count held in a register, and the pulse is active while its counter lies in the window from start to stop. A host loads these registers and a status word through an address, data and strobe write port.

The block drives active-high horizontal sync and blank, vertical sync and blank, and composite blank. It also drives two strobes, one for the last clock of a line and one for the last clock of a frame. A bank of four general output pins carries a selectable set of these signals, and each pin has its own polarity. The status word also gates the counters and records the scan mode. Equalization and serration shaping is done in a separate block downstream, which reads the scan mode from this block.

Top module: `raster_sync_gen`

## Requirements
- R1: Reset (synchronous, active high) clears every timing register and the status word, zeroes both counters and the mode error flag, and leaves every pin at 1 (the inactive level of an active-low output) with all active-high outputs and strobes at 0.
- R2: The register addresses are: 1 horizontal sync start, 2 horizontal sync stop, 3 horizontal blank length, 4 horizontal total. The pixel counter runs from 0 and returns to 0 on the clock after it reaches or passes the total. line_end_o is high while the pixel count equals the total.
- R3: The vertical registers use addresses 5 to 8, in the same order as R2. The line counter advances when the pixel counter wraps, and returns to 0 after it reaches the vertical total. frame_end_o is high when line_end_o is high and the line count equals the vertical total.
- R4: Horizontal sync is active while sync start <= pixel count < sync stop. Vertical sync uses the same rule with the line count. A window whose stop is not above its start never goes active.
- R5: Horizontal blank is active while pixel count < blank length. Vertical blank is active while line count < vertical blank length. cblank_o is the OR of the two blanks.
- R6: Status bits 2:0 route signals to pin_o[0..3]. Code 000 gives composite blank, composite sync (hsync OR vsync), horizontal gate (NOT hblank) and vertical gate (NOT vblank). Code 001 gives vblank, composite sync, hblank and vertical gate. Code 010 gives composite blank, vsync, horizontal gate and hsync. Every other code routes like 000.
- R7: Status bit 5+i sets the polarity of pin_o[i]. A 1 drives the routed signal unchanged (active high). A 0 inverts it (active low).
- R8: Status bit 10 enables counting. While it is 0, both counters hold their values, every active-high output and strobe is 0, and each pin sits at its inactive level (the inverse of its polarity bit). When the bit is set again, counting resumes from the held values.
- R9: Status bits 4:3 are the scan mode, shown on scan_mode_o. Writing code 10 keeps the previous mode and sets mode_err_o. mode_err_o stays set until reset, even after a later legal write.
- R10: Writes to addresses 9 to 31 change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register address |
| wr_data | input | 12 | Register write data |
| hsync_o | output | 1 | Horizontal sync, active high |
| hblank_o | output | 1 | Horizontal blank, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| vblank_o | output | 1 | Vertical blank, active high |
| cblank_o | output | 1 | Composite blank, active high |
| line_end_o | output | 1 | Last clock of a line |
| frame_end_o | output | 1 | Last clock of a frame |
| pin_o | output | 4 | Routed outputs with per-pin polarity |
| scan_mode_o | output | 2 | Current scan mode |
| mode_err_o | output | 1 | Sticky flag for an illegal mode write |

## Verification
A wrong pixel count shows within one line as a sync or blank edge on the wrong clock, or as a line strobe at the wrong time. A wrong line count shows within one frame on the vertical outputs and the frame strobe. The bench runs a reference count beside the design and compares every output on every cycle. A slip therefore fails on the first cycle whose decode depends on the wrong count. Routing, polarity, hold and mode-register faults show on the pins or the mode outputs on the first cycle after the write that exposes them.

// File: rtl/raster_pkg.sv
`timescale 1ns/1ps
package raster_pkg;

    localparam int CNT_W    = 12;
    localparam int ADDR_W   = 5;
    localparam int NUM_PINS = 4;
    localparam int NUM_AXES = 2;
    localparam int FIELDS   = 4;

    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_FIRST  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_LAST   = ADDR_W'(NUM_AXES * FIELDS);

    typedef enum logic [1:0] {
        SCAN_IL_DOUBLE = 2'b00,
        SCAN_NI_DOUBLE = 2'b01,
        SCAN_ILLEGAL   = 2'b10,
        SCAN_NI_SINGLE = 2'b11
    } scan_mode_e;

    typedef struct packed {
        logic       clk_en;
        logic [3:0] pol;
        scan_mode_e mode;
        logic [2:0] sel;
    } status_t;

    typedef struct packed {
        logic [CNT_W-1:0] sync_on;
        logic [CNT_W-1:0] sync_off;
        logic [CNT_W-1:0] blank_len;
        logic [CNT_W-1:0] total;
    } axis_cfg_t;

    typedef struct packed {
        logic hs;
        logic hb;
        logic vs;
        logic vb;
    } raw_t;

    function automatic status_t decode_status(input logic [CNT_W-1:0] w);
        status_t s;
        s.clk_en = w[10];
        s.pol    = w[8:5];
        s.mode   = scan_mode_e'(w[4:3]);
        s.sel    = w[2:0];
        return s;
    endfunction

    function automatic logic [NUM_PINS-1:0] route_pins(input logic [2:0] sel, input raw_t r);
        logic cb, cs;
        logic [NUM_PINS-1:0] p;
        cb = r.hb | r.vb;
        cs = r.hs | r.vs;
        case (sel)
            3'b001:  p = {~r.vb, r.hb,  cs,   r.vb};
            3'b010:  p = {r.hs,  ~r.hb, r.vs, cb};
            default: p = {~r.vb, ~r.hb, cs,   cb};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/rsg_regbank.sv
`timescale 1ns/1ps
module rsg_regbank
    import raster_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output status_t           status,
    output axis_cfg_t         cfg [NUM_AXES],
    output logic              mode_err
);

    localparam int FW = $clog2(FIELDS);

    status_t wr_stat;
    logic [ADDR_W-1:0] idx;

    assign wr_stat = decode_status(wr_data);
    assign idx     = wr_addr - A_FIRST;

    always_ff @(posedge clk) begin
        if (rst) begin
            status   <= '0;
            mode_err <= 1'b0;
        end else if (wr_en && wr_addr == A_STATUS) begin
            status.clk_en <= wr_stat.clk_en;
            status.pol    <= wr_stat.pol;
            status.sel    <= wr_stat.sel;
            if (wr_stat.mode == SCAN_ILLEGAL) begin
                mode_err <= 1'b1;
            end else begin
                status.mode <= wr_stat.mode;
            end
        end
    end

    for (genvar ax = 0; ax < NUM_AXES; ax++) begin : g_axis
        logic hit;
        logic [FW-1:0] fld;
        assign hit = wr_en && (wr_addr >= A_FIRST) && (wr_addr <= A_LAST)
                     && (int'(idx) / FIELDS == ax);
        assign fld = FW'(int'(idx) % FIELDS);
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg[ax] <= '0;
            end else if (hit) begin
                case (fld)
                    FW'(0):  cfg[ax].sync_on   <= wr_data;
                    FW'(1):  cfg[ax].sync_off  <= wr_data;
                    FW'(2):  cfg[ax].blank_len <= wr_data;
                    default: cfg[ax].total     <= wr_data;
                endcase
            end
        end
    end

    a_r9_illegal_keeps_mode: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_STATUS && wr_data[4:3] == 2'b10)
        |=> (mode_err && $stable(status.mode)));

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
        mode_err |=> mode_err);

    a_r10_no_alias: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr > A_LAST) |=> ($stable(status) && $stable(cfg[0]) && $stable(cfg[1])));

endmodule

// File: rtl/rsg_counters.sv
`timescale 1ns/1ps
module rsg_counters
    import raster_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] h_total,
    input  logic [CNT_W-1:0] v_total,
    output logic [CNT_W-1:0] h_cnt,
    output logic [CNT_W-1:0] v_cnt,
    output logic             line_last,
    output logic             frame_last
);

    assign line_last  = (h_cnt >= h_total);
    assign frame_last = line_last && (v_cnt >= v_total);

    always_ff @(posedge clk) begin
        if (rst) begin
            h_cnt <= '0;
            v_cnt <= '0;
        end else if (en) begin
            if (line_last) begin
                h_cnt <= '0;
                v_cnt <= (v_cnt >= v_total) ? '0 : CNT_W'(v_cnt + 1'b1);
            end else begin
                h_cnt <= CNT_W'(h_cnt + 1'b1);
            end
        end
    end

    a_r2_h_wraps: assert property (@(posedge clk) disable iff (rst)
        (en && h_cnt >= h_total) |=> (h_cnt == '0));

    a_r2_h_steps: assert property (@(posedge clk) disable iff (rst)
        (en && h_cnt < h_total) |=> (h_cnt == CNT_W'($past(h_cnt) + 1'b1) && $stable(v_cnt)));

    a_r3_v_steps: assert property (@(posedge clk) disable iff (rst)
        (en && h_cnt >= h_total && v_cnt < v_total) |=> (v_cnt == CNT_W'($past(v_cnt) + 1'b1)));

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(h_cnt) && $stable(v_cnt)));

endmodule

// File: rtl/rsg_window.sv
`timescale 1ns/1ps
module rsg_window #(
    parameter int W = raster_pkg::CNT_W
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] start,
    input  logic [W-1:0] stop,
    output logic         active
);

    assign active = (cnt >= start) && (cnt < stop);

endmodule

// File: rtl/raster_sync_gen.sv
`timescale 1ns/1ps
module raster_sync_gen
    import raster_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [CNT_W-1:0]    wr_data,
    output logic                hsync_o,
    output logic                hblank_o,
    output logic                vsync_o,
    output logic                vblank_o,
    output logic                cblank_o,
    output logic                line_end_o,
    output logic                frame_end_o,
    output logic [NUM_PINS-1:0] pin_o,
    output logic [1:0]          scan_mode_o,
    output logic                mode_err_o
);

    status_t          status;
    axis_cfg_t        cfg [NUM_AXES];
    logic [CNT_W-1:0] cnt [NUM_AXES];
    logic             sync_w [NUM_AXES];
    logic             blank_w [NUM_AXES];
    logic             line_last, frame_last, en;
    raw_t             raw;
    logic [NUM_PINS-1:0] routed;

    rsg_regbank u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .status   (status),
        .cfg      (cfg),
        .mode_err (mode_err_o)
    );

    assign en = status.clk_en;

    rsg_counters u_cnt (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .h_total    (cfg[0].total),
        .v_total    (cfg[1].total),
        .h_cnt      (cnt[0]),
        .v_cnt      (cnt[1]),
        .line_last  (line_last),
        .frame_last (frame_last)
    );

    for (genvar ax = 0; ax < NUM_AXES; ax++) begin : g_win
        rsg_window #(.W(CNT_W)) u_sync (
            .cnt    (cnt[ax]),
            .start  (cfg[ax].sync_on),
            .stop   (cfg[ax].sync_off),
            .active (sync_w[ax])
        );
        rsg_window #(.W(CNT_W)) u_blank (
            .cnt    (cnt[ax]),
            .start  ('0),
            .stop   (cfg[ax].blank_len),
            .active (blank_w[ax])
        );
    end

    assign raw.hs = en & sync_w[0];
    assign raw.hb = en & blank_w[0];
    assign raw.vs = en & sync_w[1];
    assign raw.vb = en & blank_w[1];

    assign hsync_o     = raw.hs;
    assign hblank_o    = raw.hb;
    assign vsync_o     = raw.vs;
    assign vblank_o    = raw.vb;
    assign cblank_o    = raw.hb | raw.vb;
    assign line_end_o  = en & line_last;
    assign frame_end_o = en & frame_last;
    assign scan_mode_o = status.mode;

    assign routed = route_pins(status.sel, raw);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        assign pin_o[p] = en ? (status.pol[p] ? routed[p] : ~routed[p]) : ~status.pol[p];
    end

    a_r8_idle_pins: assert property (@(posedge clk) disable iff (rst)
        !en |-> (pin_o == ~status.pol && !line_end_o && !cblank_o && !hsync_o && !vsync_o));

    a_r5_cblank_src: assert property (@(posedge clk) disable iff (rst)
        cblank_o |-> (hblank_o || vblank_o));

    a_r3_frame_in_line: assert property (@(posedge clk) disable iff (rst)
        frame_end_o |-> line_end_o);

endmodule

// File: tb/sim_raster_sync_gen.sv
`timescale 1ns/1ps
module sim_raster_sync_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [11:0] wr_data = '0;
    logic hsync_o, hblank_o, vsync_o, vblank_o, cblank_o, line_end_o, frame_end_o;
    logic [3:0]  pin_o;
    logic [1:0]  scan_mode_o;
    logic        mode_err_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    int hfp, hse, hbw, htot, vfp, vse, vbw, vtot;
    int mh, mv;
    bit en_m;
    logic [2:0] sel_m;
    logic [3:0] pol_m;

    always #2.5 clk = ~clk;

    raster_sync_gen u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hsync_o(hsync_o), .hblank_o(hblank_o), .vsync_o(vsync_o), .vblank_o(vblank_o),
        .cblank_o(cblank_o), .line_end_o(line_end_o), .frame_end_o(frame_end_o),
        .pin_o(pin_o), .scan_mode_o(scan_mode_o), .mode_err_o(mode_err_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        mh = 0; mv = 0; en_m = 0; sel_m = 3'b000; pol_m = 4'b0000;
    endtask

    // called at a negedge; returns at the negedge after the write edge
    task automatic wr(input logic [4:0] a, input logic [11:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [11:0] stat_word(bit en, logic [3:0] pol, logic [1:0] mode, logic [2:0] sel);
        return {1'b0, en, 1'b0, pol, mode, sel};
    endfunction

    task automatic set_status(bit en, logic [3:0] pol, logic [2:0] sel);
        wr(5'd0, stat_word(en, pol, 2'b00, sel));
        en_m = en; pol_m = pol; sel_m = sel;
    endtask

    task automatic load_cfg(int a, int b, int c, int d, int e, int f, int g, int h);
        hfp = a; hse = b; hbw = c; htot = d; vfp = e; vse = f; vbw = g; vtot = h;
        wr(5'd1, 12'(a)); wr(5'd2, 12'(b)); wr(5'd3, 12'(c)); wr(5'd4, 12'(d));
        wr(5'd5, 12'(e)); wr(5'd6, 12'(f)); wr(5'd7, 12'(g)); wr(5'd8, 12'(h));
    endtask

    function automatic logic [10:0] expect_vec();
        bit hs, hb, vs, vb, le, fe;
        logic [3:0] r, p;
        hs = en_m && mh >= hfp && mh < hse;
        hb = en_m && mh < hbw;
        vs = en_m && mv >= vfp && mv < vse;
        vb = en_m && mv < vbw;
        le = en_m && mh == htot;
        fe = le && mv == vtot;
        case (sel_m)
            3'b001:  r = {~vb, hb, hs | vs, vb};
            3'b010:  r = {hs, ~hb, vs, hb | vb};
            default: r = {~vb, ~hb, hs | vs, hb | vb};
        endcase
        for (int i = 0; i < 4; i++) p[i] = en_m ? (pol_m[i] ? r[i] : ~r[i]) : ~pol_m[i];
        return {hs, hb, vs, vb, hb | vb, le, fe, p};
    endfunction

    task automatic adv();
        if (en_m) begin
            if (mh >= htot) begin
                mh = 0;
                mv = (mv >= vtot) ? 0 : mv + 1;
            end else begin
                mh++;
            end
        end
    endtask

    task automatic run_cmp(int n, string req);
        for (int i = 0; i < n; i++) begin
            logic [10:0] got, exp;
            got = {hsync_o, hblank_o, vsync_o, vblank_o, cblank_o, line_end_o, frame_end_o, pin_o};
            exp = expect_vec();
            chk(got == exp, req, 32'(got), 32'(exp));
            @(negedge clk);
            adv();
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk(pin_o == 4'hF, "R1 pins", 32'(pin_o), 32'hF);
        chk({hsync_o, hblank_o, vsync_o, vblank_o, cblank_o, line_end_o, frame_end_o} == 7'd0,
            "R1 outputs", 32'({hsync_o, hblank_o, vsync_o, vblank_o, cblank_o, line_end_o, frame_end_o}), 0);
        chk(scan_mode_o == 2'b00 && !mode_err_o, "R1 mode", 32'({scan_mode_o, mode_err_o}), 0);
    endtask

    task automatic t_basic();
        do_reset();
        load_cfg(2, 4, 3, 9, 1, 2, 2, 5);
        set_status(1'b1, 4'b0000, 3'b000);
        run_cmp(150, "R2 R3 R4 R5 R6 basic");
    endtask

    task automatic t_routes();
        do_reset();
        load_cfg(5, 3, 4, 11, 0, 3, 1, 4);   // empty horizontal sync window (R4)
        set_status(1'b1, 4'b1010, 3'b001);
        run_cmp(70, "R6 R7 R4 route001");
        do_reset();
        load_cfg(1, 6, 2, 7, 2, 4, 3, 6);
        set_status(1'b1, 4'b0110, 3'b010);
        run_cmp(70, "R6 R7 route010");
        do_reset();
        load_cfg(1, 6, 2, 7, 2, 4, 3, 6);
        set_status(1'b1, 4'b1111, 3'b101);
        run_cmp(70, "R6 R7 route101");
    endtask

    task automatic t_hold();
        do_reset();
        load_cfg(2, 5, 3, 8, 1, 3, 2, 4);
        set_status(1'b1, 4'b1001, 3'b000);
        run_cmp(37, "R8 pre");
        wr(5'd0, stat_word(1'b0, 4'b1001, 2'b00, 3'b000));
        adv();
        en_m = 0;
        run_cmp(12, "R8 disabled idle");
        chk(pin_o == 4'b0110, "R8 inactive pins", 32'(pin_o), 32'h6);
        set_status(1'b1, 4'b1001, 3'b000);
        run_cmp(60, "R8 resume");
    endtask

    task automatic t_mode();
        do_reset();
        wr(5'd0, stat_word(1'b0, 4'b0000, 2'b01, 3'b000));
        chk(scan_mode_o == 2'b01 && !mode_err_o, "R9 mode01", 32'({scan_mode_o, mode_err_o}), 32'h2);
        wr(5'd0, stat_word(1'b0, 4'b0000, 2'b11, 3'b000));
        chk(scan_mode_o == 2'b11 && !mode_err_o, "R9 mode11", 32'({scan_mode_o, mode_err_o}), 32'h6);
        wr(5'd0, stat_word(1'b0, 4'b0000, 2'b10, 3'b000));
        chk(scan_mode_o == 2'b11 && mode_err_o, "R9 illegal", 32'({scan_mode_o, mode_err_o}), 32'h7);
        wr(5'd0, stat_word(1'b0, 4'b0000, 2'b00, 3'b000));
        chk(scan_mode_o == 2'b00 && mode_err_o, "R9 sticky", 32'({scan_mode_o, mode_err_o}), 32'h1);
        do_reset();
        chk(!mode_err_o, "R1 err cleared", 32'(mode_err_o), 0);
    endtask

    task automatic t_badaddr();
        do_reset();
        load_cfg(2, 4, 3, 9, 1, 2, 2, 5);
        wr(5'd9, 12'hFFF); wr(5'd12, 12'h400); wr(5'd16, 12'h7FF); wr(5'd31, 12'h5A5);
        chk(pin_o == 4'hF && !line_end_o, "R10 still idle", 32'({pin_o, line_end_o}), 32'h1E);
        set_status(1'b1, 4'b0011, 3'b000);
        wr(5'd24, 12'h000);
        adv();
        run_cmp(80, "R10 timing unchanged");
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic();
        t_routes();
        t_hold();
        t_mode();
        t_badaddr();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule